// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Window

This block decodes a 16-byte I/O window that holds the per-channel control registers of a two-channel bus-master DMA function. Each channel owns an 8-byte slice. Its first four bytes are a command byte, an alias of a mode/interrupt byte shared by both channels, a status byte and an ultra-DMA timing byte. Its last four bytes form the descriptor-address port. This block only decodes that port and reports a select to the logic that owns it.

The host reaches the window through a byte-oriented read/write port with a size code. Command writes go to the DMA engine as a one-cycle strobe. Writes to the shared mode byte leave as a merged byte on a side port, together with a strobe that asks the interrupt logic to re-evaluate. The engine sets the error and interrupt flags in each status byte through set strobes. All outputs are registered, so read data appears one cycle after the access.

Top module: `bmdma_win`

## Requirements
- R1: Address bit 3 selects the channel. Address bit 2 clear selects that channel's control bytes, and the low two bits then pick the register: 0 command, 1 shared mode byte, 2 status, 3 timing. At most one of the command, mode and descriptor strobes is active in any cycle.
- R2: Size code 0 is a byte access, code 1 is a 16-bit access, and codes 2 and 3 are 32-bit accesses. A wider read returns 0x0000FFFF for code 1 and 0xFFFFFFFF for codes 2 and 3. A wider write changes no register and raises no strobe.
- R3: A byte write to register 0 raises `cmd_stb` for one cycle, on the cycle after the access, carrying the channel and the data byte. A byte read of register 0 returns the last command byte written to that channel.
- R4: A byte write to register 1 drives `mode_wr_data` with `mode_in` for every bit except bits 4 and 5, which are taken from the written data. `mode_wr_en` and `irq_reeval` are both high for that one cycle.
- R5: A byte read of register 1 in either channel returns `mode_in`.
- R6: The status byte reads as bit 0 = `eng_active` of the channel, bit 1 = error, bit 2 = interrupt, bits 5 and 6 = host-writable bits, and bits 3, 4 and 7 = 0. A status write loads bits 5 and 6 from the data and clears error and interrupt where the data bit is 1.
- R7: A set strobe from the engine sets the error or interrupt flag. If a host write clears the same flag in the same cycle, the set wins.
- R8: Each channel has its own 8-bit timing register at register 3. It is read and written as a byte, and writing one channel leaves the other unchanged.
- R9: A byte access with address bit 2 set raises `desc_sel` for one cycle, with the channel and the low two address bits. It reads as zero and changes no register in this block.
- R10: After synchronous reset, all registers, the status flags, read data and strobes are zero.
- R11: `host_rvalid` is high exactly on the cycle after a read access, and `host_rdata` is valid on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Byte address within the window |
| host_size | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| host_wdata | input | 32 | Write data, byte in bits 7:0 |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid |
| eng_active | input | 2 | Engine busy flag per channel |
| eng_err_set | input | 2 | Set error flag per channel |
| eng_irq_set | input | 2 | Set interrupt flag per channel |
| cmd_stb | output | 1 | Command write strobe to the engine |
| cmd_chan | output | 1 | Channel of the command write |
| cmd_data | output | 8 | Command byte |
| mode_in | input | 8 | Current shared mode byte |
| mode_wr_en | output | 1 | Shared mode byte update strobe |
| mode_wr_data | output | 8 | Merged new shared mode byte |
| irq_reeval | output | 1 | Interrupt re-evaluation request |
| desc_sel | output | 1 | Descriptor-address port access |
| desc_chan | output | 1 | Channel of the descriptor access |
| desc_off | output | 2 | Byte offset within the descriptor port |

## Verification
The bench sweeps every data value through the status byte. It catches a design that clears on written zeros, a design that lets bit 0 or the unused bits be written, and a design whose set strobe loses to a clear in the same cycle. It walks every address with every size code. A design that decodes wide accesses as bytes would return register contents or raise strobes, and a design that fills the wrong width of ones would show up as a mismatch. Timing registers are written with complementary values per channel, so writes that leak into the wrong channel are exposed. Mode writes under several `mode_in` patterns catch merges that take the wrong bits from the host.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2,
    REG_TIM  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  // host-owned bits of the shared mode byte
  localparam logic [7:0] MODE_HOST_MASK = 8'h30;
endpackage

// File: rtl/bmw_decode.sv
module bmw_decode #(
  parameter int NCH  = 2,
  parameter int CH_W = 1,
  parameter int AW   = CH_W + 3
) (
  input  logic [AW-1:0]        addr,
  output logic [CH_W-1:0]      ch,
  output logic                 ch_ok,
  output logic                 is_desc,
  output bmw_pkg::reg_sel_e    rsel,
  output logic [1:0]           off
);
  assign ch      = addr[AW-1:3];
  assign is_desc = addr[2];
  assign off     = addr[1:0];
  assign rsel    = bmw_pkg::reg_sel_e'(addr[1:0]);

  generate
    if ((2 ** CH_W) == NCH) begin : g_full
      assign ch_ok = 1'b1;
    end else begin : g_part
      assign ch_ok = ({1'b0, ch} < (CH_W + 1)'(NCH));
    end
  endgenerate
endmodule

// File: rtl/bmw_status.sv
module bmw_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       act,
  input  logic       err_set,
  input  logic       irq_set,
  output logic [7:0] stat
);
  logic err_q, irq_q, b5_q, b6_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
      b5_q  <= 1'b0;
      b6_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        b5_q <= wdata[5];
        b6_q <= wdata[6];
      end
      // set strobe has priority over a host clear
      err_q <= err_set | (err_q & ~(wr_en & wdata[1]));
      irq_q <= irq_set | (irq_q & ~(wr_en & wdata[2]));
    end
  end

  assign stat = {1'b0, b6_q, b5_q, 2'b00, irq_q, err_q, act};
endmodule

// File: rtl/bmdma_win.sv
module bmdma_win #(
  parameter int NCH = 2,
  parameter int DW  = 32,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW   = CH_W + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_valid,
  input  logic            host_write,
  input  logic [AW-1:0]   host_addr,
  input  logic [1:0]      host_size,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_rvalid,
  input  logic [NCH-1:0]  eng_active,
  input  logic [NCH-1:0]  eng_err_set,
  input  logic [NCH-1:0]  eng_irq_set,
  output logic            cmd_stb,
  output logic [CH_W-1:0] cmd_chan,
  output logic [7:0]      cmd_data,
  input  logic [7:0]      mode_in,
  output logic            mode_wr_en,
  output logic [7:0]      mode_wr_data,
  output logic            irq_reeval,
  output logic            desc_sel,
  output logic [CH_W-1:0] desc_chan,
  output logic [1:0]      desc_off
);
  import bmw_pkg::*;

  localparam logic [DW-1:0] HALF_ONES = {{(DW-16){1'b0}}, 16'hFFFF};

  logic [CH_W-1:0] ch;
  logic            ch_ok, is_desc;
  reg_sel_e        rsel;
  logic [1:0]      off;

  bmw_decode #(.NCH(NCH), .CH_W(CH_W), .AW(AW)) u_dec (
    .addr(host_addr), .ch(ch), .ch_ok(ch_ok), .is_desc(is_desc),
    .rsel(rsel), .off(off)
  );

  logic byte_acc, wr_byte, wr_ctl;
  assign byte_acc = host_valid && (acc_size_e'(host_size) == SZ_BYTE) && ch_ok;
  assign wr_byte  = byte_acc && host_write;
  assign wr_ctl   = wr_byte && !is_desc;

  logic unused_wbits;
  assign unused_wbits = ^host_wdata[DW-1:8];

  logic [7:0] stat_v [NCH];
  logic [7:0] tim_v  [NCH];
  logic [7:0] cmd_v  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic       hit;
    logic [7:0] tim_r, cmd_r;
    assign hit = wr_ctl && (ch == CH_W'(g));

    bmw_status u_st (
      .clk(clk), .rst(rst),
      .wr_en(hit && (rsel == REG_STAT)),
      .wdata(host_wdata[7:0]),
      .act(eng_active[g]),
      .err_set(eng_err_set[g]),
      .irq_set(eng_irq_set[g]),
      .stat(stat_v[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        tim_r <= 8'h00;
        cmd_r <= 8'h00;
      end else begin
        if (hit && (rsel == REG_TIM)) tim_r <= host_wdata[7:0];
        if (hit && (rsel == REG_CMD)) cmd_r <= host_wdata[7:0];
      end
    end

    assign tim_v[g] = tim_r;
    assign cmd_v[g] = cmd_r;
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (acc_size_e'(host_size))
      SZ_HALF: rd_next = HALF_ONES;
      SZ_WORD, SZ_WALT: rd_next = '1;
      default: begin
        if (ch_ok && !is_desc) begin
          case (rsel)
            REG_CMD:  rd_next[7:0] = cmd_v[ch];
            REG_MODE: rd_next[7:0] = mode_in;
            REG_STAT: rd_next[7:0] = stat_v[ch];
            default:  rd_next[7:0] = tim_v[ch];
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata   <= '0;
      host_rvalid  <= 1'b0;
      cmd_stb      <= 1'b0;
      cmd_chan     <= '0;
      cmd_data     <= 8'h00;
      mode_wr_en   <= 1'b0;
      mode_wr_data <= 8'h00;
      irq_reeval   <= 1'b0;
      desc_sel     <= 1'b0;
      desc_chan    <= '0;
      desc_off     <= 2'b00;
    end else begin
      host_rvalid <= host_valid && !host_write;
      if (host_valid && !host_write) host_rdata <= rd_next;
      cmd_stb    <= wr_ctl && (rsel == REG_CMD);
      mode_wr_en <= wr_ctl && (rsel == REG_MODE);
      irq_reeval <= wr_ctl && (rsel == REG_MODE);
      desc_sel   <= byte_acc && is_desc;
      if (wr_ctl && (rsel == REG_CMD)) begin
        cmd_chan <= ch;
        cmd_data <= host_wdata[7:0];
      end
      if (wr_ctl && (rsel == REG_MODE))
        mode_wr_data <= (mode_in & ~MODE_HOST_MASK) | (host_wdata[7:0] & MODE_HOST_MASK);
      if (byte_acc && is_desc) begin
        desc_chan <= ch;
        desc_off  <= off;
      end
    end
  end
endmodule

// File: rtl/bmdma_win_chk.sv
module bmdma_win_chk #(
  parameter int NCH = 2,
  parameter int DW  = 32,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW   = CH_W + 3
) (
  input logic            clk,
  input logic            rst,
  input logic            host_valid,
  input logic            host_write,
  input logic [AW-1:0]   host_addr,
  input logic [1:0]      host_size,
  input logic [DW-1:0]   host_wdata,
  input logic [DW-1:0]   host_rdata,
  input logic            host_rvalid,
  input logic            cmd_stb,
  input logic [CH_W-1:0] cmd_chan,
  input logic [7:0]      cmd_data,
  input logic [7:0]      mode_in,
  input logic            mode_wr_en,
  input logic [7:0]      mode_wr_data,
  input logic            irq_reeval,
  input logic            desc_sel
);
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_stb, mode_wr_en, desc_sel}));

  a_r2_wide_quiet: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_size != 2'd0) |=> (!cmd_stb && !mode_wr_en && !desc_sel));

  a_r2_word_ones: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !host_write && host_size[1]) |=> (host_rdata == {DW{1'b1}}));

  a_r3_cmd_fwd: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_write && host_size == 2'd0 && host_addr[2:0] == 3'd0)
      |=> (cmd_stb && cmd_data == $past(host_wdata[7:0])
           && cmd_chan == $past(host_addr[AW-1:3])));

  a_r4_mode_merge: assert property (@(posedge clk) disable iff (rst)
    mode_wr_en |-> (irq_reeval && ((mode_wr_data & 8'hCF) == ($past(mode_in) & 8'hCF))));

  a_r9_desc_zero: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !host_write && host_size == 2'd0 && host_addr[2])
      |=> (host_rvalid && host_rdata == '0));

  a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !host_write) |=> host_rvalid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!host_valid || host_write) |=> !host_rvalid);
endmodule

bind bmdma_win bmdma_win_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/tb_bmdma_win.sv
module tb_bmdma_win;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_valid, host_write;
  logic [3:0]  host_addr;
  logic [1:0]  host_size;
  logic [31:0] host_wdata, host_rdata;
  logic        host_rvalid;
  logic [1:0]  eng_active, eng_err_set, eng_irq_set;
  logic        cmd_stb, mode_wr_en, irq_reeval, desc_sel;
  logic [0:0]  cmd_chan, desc_chan;
  logic [7:0]  cmd_data, mode_in, mode_wr_data;
  logic [1:0]  desc_off;

  int vecs = 0, errs = 0;
  bit done = 0;

  logic [7:0] m_cmd [2];
  logic [7:0] m_tim [2];
  logic       m_err [2], m_irq [2], m_b5 [2], m_b6 [2];

  always #10 clk = ~clk;

  bmdma_win dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [3:0] a, logic [1:0] sz);
    int c = a[3];
    if (sz == 2'd1) return 32'h0000FFFF;
    if (sz[1]) return 32'hFFFFFFFF;
    if (a[2]) return 32'h0;
    case (a[1:0])
      2'd0: return {24'h0, m_cmd[c]};
      2'd1: return {24'h0, mode_in};
      2'd2: return {24'h0, 1'b0, m_b6[c], m_b5[c], 2'b00, m_irq[c], m_err[c], eng_active[c]};
      default: return {24'h0, m_tim[c]};
    endcase
  endfunction

  // one access, with optional engine set strobes in the same cycle
  task automatic acc(bit wr, logic [3:0] a, logic [1:0] sz, logic [31:0] d,
                     logic [1:0] es = 2'b00, logic [1:0] is = 2'b00);
    int c = a[3];
    @(negedge clk);
    host_valid = 1; host_write = wr; host_addr = a; host_size = sz; host_wdata = d;
    eng_err_set = es; eng_irq_set = is;
    @(negedge clk);
    host_valid = 0; host_write = 0; eng_err_set = 0; eng_irq_set = 0;
    if (wr && sz == 2'd0 && !a[2]) begin
      case (a[1:0])
        2'd0: m_cmd[c] = d[7:0];
        2'd2: begin
          m_b5[c] = d[5]; m_b6[c] = d[6];
          m_err[c] = m_err[c] & ~d[1];
          m_irq[c] = m_irq[c] & ~d[2];
        end
        2'd3: m_tim[c] = d[7:0];
        default: ;
      endcase
    end
    for (int k = 0; k < 2; k++) begin
      if (es[k]) m_err[k] = 1;
      if (is[k]) m_irq[k] = 1;
    end
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [1:0] sz);
    logic [31:0] e = exp_rd(a, sz);
    acc(0, a, sz, 32'h0);
    check({req, " rvalid"}, {31'h0, host_rvalid}, 32'd1);
    check(req, host_rdata, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rst = 1; host_valid = 0; host_write = 0; host_addr = 0; host_size = 0;
    host_wdata = 0; eng_active = 0; eng_err_set = 0; eng_irq_set = 0; mode_in = 8'h00;
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 0; m_tim[c] = 0; m_err[c] = 0; m_irq[c] = 0; m_b5[c] = 0; m_b6[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state of outputs
    check("R10 rdata", host_rdata, 32'h0);
    check("R10 strobes", {28'h0, host_rvalid, cmd_stb, mode_wr_en, desc_sel}, 32'h0);
    for (int a = 0; a < 16; a++) rd_chk("R10 reset read", 4'(a), 2'd0);

    // R2: every address with every wide size code
    mode_in = 8'h5A;
    for (int a = 0; a < 16; a++)
      for (int s = 1; s < 4; s++) rd_chk("R2 wide read", 4'(a), 2'(s));

    // R8: timing registers, complementary values per channel
    for (int v = 0; v < 256; v++) begin
      acc(1, 4'd3, 2'd0, 32'(v));
      acc(1, 4'd11, 2'd0, 32'(8'(~v)));
      rd_chk("R8 timing ch0", 4'd3, 2'd0);
      rd_chk("R8 timing ch1", 4'd11, 2'd0);
    end

    // R2: wide writes change nothing and raise no strobe
    for (int s = 1; s < 4; s++) begin
      acc(1, 4'd3, 2'(s), 32'h11223344);
      check("R2 wide write strobes", {29'h0, cmd_stb, mode_wr_en, desc_sel}, 32'h0);
      acc(1, 4'd0, 2'(s), 32'hFFFFFFFF);
      check("R2 wide cmd write no strobe", {31'h0, cmd_stb}, 32'h0);
      acc(1, 4'd10, 2'(s), 32'hFFFFFFFF);
      rd_chk("R2 timing after wide write", 4'd3, 2'd0);
      rd_chk("R2 status after wide write", 4'd10, 2'd0);
    end

    // R6/R7: full sweep of status write data
    for (int c = 0; c < 2; c++) begin
      for (int d = 0; d < 256; d++) begin
        eng_active = 2'(d % 4);
        acc(0, 4'd0, 2'd1, 32'h0, 2'b11, 2'b11);
        rd_chk("R7 set strobe", 4'(c*8 + 2), 2'd0);
        acc(1, 4'(c*8 + 2), 2'd0, 32'(d));
        rd_chk("R6 status write", 4'(c*8 + 2), 2'd0);
        rd_chk("R6 other channel status", 4'((1-c)*8 + 2), 2'd0);
      end
      // R7: set wins over simultaneous clear
      acc(1, 4'(c*8 + 2), 2'd0, 32'h06, 2'(1 << c), 2'(1 << c));
      rd_chk("R7 set beats clear", 4'(c*8 + 2), 2'd0);
      check("R7 flags kept", {30'h0, m_irq[c], m_err[c]}, 32'h3);
    end

    // R3: command forwarding and readback
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 256; v += 37) begin
        acc(1, 4'(c*8), 2'd0, 32'(v) | 32'hABCD0000);
        check("R3 cmd strobe", {23'h0, cmd_stb, cmd_chan, 7'h0}, {23'h0, 1'b1, 1'(c), 7'h0});
        check("R3 cmd data", {24'h0, cmd_data}, 32'(v));
        rd_chk("R3 cmd readback", 4'(c*8), 2'd0);
      end

    // R4/R5: shared mode byte
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 8; p++) begin
        logic [7:0] mi = 8'(p * 8'h29 + 8'h13);
        logic [7:0] dv = 8'(~mi ^ (p * 8'h11));
        mode_in = mi;
        acc(1, 4'(c*8 + 1), 2'd0, {24'hFFFFFF, dv});
        check("R4 mode strobes", {30'h0, mode_wr_en, irq_reeval}, 32'h3);
        check("R4 mode merge", {24'h0, mode_wr_data}, {24'h0, (mi & 8'hCF) | (dv & 8'h30)});
        check("R1 no cmd on mode write", {31'h0, cmd_stb}, 32'h0);
        rd_chk("R5 mode read", 4'(c*8 + 1), 2'd0);
      end

    // R9: descriptor port decode
    for (int a = 0; a < 16; a++) if (a[2]) begin
      acc(1, 4'(a), 2'd0, 32'hFF);
      check("R9 desc select", {27'h0, desc_sel, desc_chan, desc_off, 1'b0},
            {27'h0, 1'b1, 1'(a >> 3), 2'(a), 1'b0});
      check("R1 desc only strobe", {30'h0, cmd_stb, mode_wr_en}, 32'h0);
      rd_chk("R9 desc read zero", 4'(a), 2'd0);
      rd_chk("R9 cmd untouched", 4'(a & 8), 2'd0);
      rd_chk("R9 timing untouched", 4'((a & 8) | 3), 2'd0);
    end

    // R11: no rvalid after a write
    acc(1, 4'd3, 2'd0, 32'h5);
    check("R11 no rvalid on write", {31'h0, host_rvalid}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule